// File: doc/BRIEF.md
# Pixel-Doubling Stateless TMDS Channel Encoder

This block turns one colour channel of a half-width pixel stream into 10-bit TMDS line symbols, one symbol per pixel-clock cycle. Every active sample is shown twice. The first copy is encoded with bit 0 cleared and the second with bit 0 set. Encoded from zero disparity, such a pair always comes out with zero net disparity. The block therefore needs no disparity counter: a 128-entry table of balanced symbol pairs, computed when the design is elaborated, does all the encoding. Its output still matches, symbol for symbol, what the full disparity-tracking TMDS algorithm produces for the same doubled sequence.

Samples arrive on a valid/ready stream. Each sample carries the 8-bit channel value, a data-enable flag and two sync bits. A blanking sample takes one cycle and yields one control symbol. An active sample takes two cycles and yields a symbol pair. When the stream runs dry, the lane repeats the control symbol of the most recent blanking sync value. The `ALIGN_PAIRS` option keeps every active pair on an even position of a free-running two-cycle grid. When it is set, an active sample that arrives on an odd grid cycle waits one cycle for the next pair boundary.

Top module: `tmds_pd_enc`

## Requirements
- R1: After reset, `sym_o` is the control symbol for sync 00 (10'b1101010100), `de_o` is 0 and `in_ready` is 1.
- R2: A blanking sample (`in_de`=0) is taken in one cycle. In the next cycle `sym_o` carries the control symbol chosen by `in_sync`={c1,c0}: 00 gives 10'b1101010100, 01 gives 10'b0010101011, 10 gives 10'b0101010100 and 11 gives 10'b1010101011. The symbol is written with bit 9 as the leftmost bit.
- R3: An active sample with upper bits v=`in_data[7:1]` yields two consecutive symbols. They equal the standard TMDS encoding, started from zero disparity, of {v,0} and then {v,1}. Each pair has exactly 10 ones in its 20 bits.
- R4: `in_data[0]` of an active sample has no effect on the emitted symbols.
- R5: In the cycle after an active sample is taken, `in_ready` is 0. The block therefore accepts at most one active sample per two cycles.
- R6: In a cycle where no pair is in progress and no sample is taken, `sym_o` repeats the control symbol of the most recent blanking sample's sync bits. The sync bits of active samples do not change this remembered value.
- R7: With `ALIGN_PAIRS`=1, an active sample is accepted only when an even number of cycles has passed since reset; on odd cycles `in_ready` is 0 while `in_de` is 1. With `ALIGN_PAIRS`=0, an active sample is accepted on any cycle outside a pair.
- R8: `de_o` is 1 during exactly the two output cycles of each symbol pair and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts the presented sample this cycle |
| in_de | input | 1 | Sample is active video (1) or blanking (0) |
| in_sync | input | 2 | Sync bits {c1,c0} used during blanking |
| in_data | input | 8 (CHAN_W) | Channel value; bit 0 is ignored |
| sym_o | output | 10 | TMDS line symbol, bit 0 sent first |
| de_o | output | 1 | Current symbol is a data symbol |

## Verification
The bench builds the block twice. The first build keeps the default `ALIGN_PAIRS`=1, so the scoreboard can make active samples land on odd grid cycles and observe the one-cycle stall at the pair boundary. The second build sets `ALIGN_PAIRS`=0, which shows an active sample being taken right after a single blanking cycle. The aligned build also receives all 256 channel values back to back, and every output is compared with a disparity-tracking model of the full algorithm. That sweep covers the whole pair table together with the zero-disparity return after each pair.

// File: rtl/tmds_pd_pkg.sv
`timescale 1ns/1ps
package tmds_pd_pkg;

   localparam int TMDS_DW = 8;
   localparam int SYM_W   = 10;

   typedef logic [SYM_W-1:0] tmds_sym_t;

   typedef struct packed {
      tmds_sym_t first;
      tmds_sym_t second;
   } tmds_pair_t;

   typedef struct packed {
      tmds_sym_t         sym;
      logic signed [7:0] bal;
   } tmds_res_t;

   // one symbol of the full disparity-tracking encoder
   function automatic tmds_res_t tmds_step(input logic [7:0] d, input logic signed [7:0] bal_in);
      logic [8:0] qm;
      int         ones_d;
      int         ones_q;
      int         diff;
      int         b_in;
      int         b_out;
      logic       use_xnor;
      tmds_res_t  r;
      ones_d   = $countones(d);
      use_xnor = (ones_d > 4) || ((ones_d == 4) && !d[0]);
      qm[0]    = d[0];
      for (int i = 1; i < 8; i++) begin
         qm[i] = use_xnor ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
      end
      qm[8]  = ~use_xnor;
      ones_q = $countones(qm[7:0]);
      diff   = 2 * ones_q - 8;
      b_in   = int'(bal_in);
      if ((b_in == 0) || (ones_q == 4)) begin
         r.sym = {~qm[8], qm[8], (qm[8] ? qm[7:0] : ~qm[7:0])};
         b_out = qm[8] ? (b_in + diff) : (b_in - diff);
      end else if (((b_in > 0) && (ones_q > 4)) || ((b_in < 0) && (ones_q < 4))) begin
         r.sym = {1'b1, qm[8], ~qm[7:0]};
         b_out = b_in + 2 * int'(qm[8]) - diff;
      end else begin
         r.sym = {1'b0, qm[8], qm[7:0]};
         b_out = b_in - 2 * int'(~qm[8]) + diff;
      end
      r.bal = 8'(b_out);
      return r;
   endfunction

   // balanced pair for the upper seven bits: {v,0} then {v,1} from zero disparity
   function automatic tmds_pair_t pair_of(input logic [6:0] v);
      tmds_res_t  a;
      tmds_res_t  b;
      tmds_pair_t p;
      a = tmds_step({v, 1'b0}, 8'sd0);
      b = tmds_step({v, 1'b1}, a.bal);
      p.first  = a.sym;
      p.second = b.sym;
      return p;
   endfunction

   function automatic tmds_sym_t ctrl_sym(input logic [1:0] code);
      tmds_sym_t s;
      case (code)
         2'b00:   s = 10'b1101010100;
         2'b01:   s = 10'b0010101011;
         2'b10:   s = 10'b0101010100;
         default: s = 10'b1010101011;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/tmds_pd_pair_rom.sv
`timescale 1ns/1ps
module tmds_pd_pair_rom
   import tmds_pd_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  logic [IDX_W-1:0] idx,
   output tmds_pair_t       pair
);

   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W != TMDS_DW - 1) begin : g_bad_idx
      $error("tmds_pd_pair_rom: IDX_W must be one less than the TMDS data width");
   end

   tmds_pair_t rom_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      localparam tmds_pair_t ENT = pair_of(7'(e));
      assign rom_q[e] = ENT;
   end

   assign pair = rom_q[idx];

endmodule

// File: rtl/tmds_pd_pacer.sv
`timescale 1ns/1ps
module tmds_pd_pacer #(
   parameter bit ALIGN_PAIRS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_de,
   input  logic busy,
   output logic in_ready
);

   logic slot_ok;

   if (ALIGN_PAIRS) begin : g_grid
      logic odd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) odd_q <= 1'b0;
         else        odd_q <= ~odd_q;
      end
      assign slot_ok = ~odd_q;
   end else begin : g_free
      assign slot_ok = 1'b1;
   end

   // an active sample starts a pair only on a free boundary
   assign in_ready = ~busy & (~in_de | slot_ok);

endmodule

// File: rtl/tmds_pd_enc.sv
`timescale 1ns/1ps
module tmds_pd_enc
   import tmds_pd_pkg::*;
#(
   parameter int CHAN_W      = 8,
   parameter bit ALIGN_PAIRS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_de,
   input  logic [1:0]        in_sync,
   input  logic [CHAN_W-1:0] in_data,
   output logic [SYM_W-1:0]  sym_o,
   output logic              de_o
);

   localparam int IDX_W = CHAN_W - 1;

   if (CHAN_W != TMDS_DW) begin : g_bad_chan
      $error("tmds_pd_enc: CHAN_W must equal the TMDS data width");
   end

   logic       busy_q;
   tmds_sym_t  hold_q;
   logic [1:0] sync_q;
   tmds_sym_t  sym_q;
   logic       de_q;
   logic       take;
   logic [1:0] ctrl_code;
   tmds_pair_t pair;
   logic       unused_lsb;

   assign unused_lsb = in_data[0];

   tmds_pd_pacer #(.ALIGN_PAIRS(ALIGN_PAIRS)) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_de    (in_de),
      .busy     (busy_q),
      .in_ready (in_ready)
   );

   tmds_pd_pair_rom #(.IDX_W(IDX_W)) u_rom (
      .idx  (in_data[CHAN_W-1:1]),
      .pair (pair)
   );

   assign take      = in_valid & in_ready;
   assign ctrl_code = (take && !in_de) ? in_sync : sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         hold_q <= '0;
         sync_q <= 2'b00;
         sym_q  <= ctrl_sym(2'b00);
         de_q   <= 1'b0;
      end else if (busy_q) begin
         sym_q  <= hold_q;
         de_q   <= 1'b1;
         busy_q <= 1'b0;
      end else if (take && in_de) begin
         sym_q  <= pair.first;
         hold_q <= pair.second;
         de_q   <= 1'b1;
         busy_q <= 1'b1;
      end else begin
         sym_q <= ctrl_sym(ctrl_code);
         de_q  <= 1'b0;
         if (take) sync_q <= in_sync;
      end
   end

   assign sym_o = sym_q;
   assign de_o  = de_q;

endmodule

// File: rtl/tmds_pd_enc_chk.sv
`timescale 1ns/1ps
module tmds_pd_enc_chk
   import tmds_pd_pkg::*;
#(
   parameter bit ALIGN_PAIRS = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_de,
   input logic [1:0]       in_sync,
   input logic [SYM_W-1:0] sym_o,
   input logic             de_o
);

   logic take_act;
   logic take_blank;
   logic odd_c;

   assign take_act   = in_valid & in_ready & in_de;
   assign take_blank = in_valid & in_ready & ~in_de;

   always_ff @(posedge clk) begin
      if (!rst_n) odd_c <= 1'b0;
      else        odd_c <= ~odd_c;
   end

   p_second_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take_act |=> !in_ready);

   p_pair_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take_act |=> de_o);

   p_pair_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(take_act) |=> de_o);

   p_pair_balanced_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(take_act, 2) |-> (($countones(sym_o) + $countones($past(sym_o))) == 10));

   p_ctrl_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !de_o |-> ((sym_o == 10'b1101010100) || (sym_o == 10'b0010101011) ||
                 (sym_o == 10'b0101010100) || (sym_o == 10'b1010101011)));

   p_blank_sym_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take_blank |=> (!de_o && (sym_o == ctrl_sym($past(in_sync)))));

   if (ALIGN_PAIRS) begin : g_align_chk
      p_grid_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
         take_act |-> !odd_c);
   end

endmodule

bind tmds_pd_enc tmds_pd_enc_chk #(.ALIGN_PAIRS(ALIGN_PAIRS)) u_chk (.*);

// File: tb/tmds_pd_enc_tb_top.sv
`timescale 1ns/1ps
module tmds_pd_enc_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_de = 1'b0;
   logic [1:0] in_sync = 2'b00;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic [9:0] sym_o;
   logic       de_o;

   logic       f_valid = 1'b0;
   logic       f_de = 1'b0;
   logic [1:0] f_sync = 2'b00;
   logic [7:0] f_data = 8'h00;
   logic       f_ready;
   logic [9:0] f_sym;
   logic       f_deo;

   always #2.5 clk = ~clk;

   tmds_pd_enc #(.CHAN_W(8), .ALIGN_PAIRS(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_de(in_de), .in_sync(in_sync), .in_data(in_data), .sym_o(sym_o), .de_o(de_o));

   tmds_pd_enc #(.CHAN_W(8), .ALIGN_PAIRS(1'b0)) dut_free_i (
      .clk(clk), .rst_n(rst_n), .in_valid(f_valid), .in_ready(f_ready),
      .in_de(f_de), .in_sync(f_sync), .in_data(f_data), .sym_o(f_sym), .de_o(f_deo));

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [9:0] q_sym [$];
   bit         q_de  [$];
   string      q_tag [$];

   bit         b_busy = 1'b0;
   bit         b_odd  = 1'b0;
   logic [9:0] b_hold = '0;
   logic [1:0] b_last = 2'b00;
   int         b_cnt  = 0;
   bit         b_prev_de = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [9:0] b_ctrl(input logic [1:0] c);
      case (c)
         2'b00:   return 10'b1101010100;
         2'b01:   return 10'b0010101011;
         2'b10:   return 10'b0101010100;
         default: return 10'b1010101011;
      endcase
   endfunction

   // full reference encoder with its own disparity counter
   function automatic logic [9:0] b_enc(input logic [7:0] d, inout int cnt);
      int         n1;
      int         a;
      int         z;
      logic [8:0] q;
      logic [9:0] o;
      n1 = 0;
      for (int i = 0; i < 8; i++) n1 += int'(d[i]);
      q[0] = d[0];
      if ((n1 > 4) || ((n1 == 4) && (d[0] == 1'b0))) begin
         for (int i = 1; i < 8; i++) q[i] = q[i-1] ~^ d[i];
         q[8] = 1'b0;
      end else begin
         for (int i = 1; i < 8; i++) q[i] = q[i-1] ^ d[i];
         q[8] = 1'b1;
      end
      a = 0;
      for (int i = 0; i < 8; i++) a += int'(q[i]);
      z = 8 - a;
      if ((cnt == 0) || (a == z)) begin
         o[9]   = ~q[8];
         o[8]   = q[8];
         o[7:0] = q[8] ? q[7:0] : ~q[7:0];
         if (q[8] == 1'b0) cnt = cnt + (z - a);
         else              cnt = cnt + (a - z);
      end else if (((cnt > 0) && (a > z)) || ((cnt < 0) && (z > a))) begin
         o   = {1'b1, q[8], ~q[7:0]};
         cnt = cnt + 2 * int'(q[8]) + (z - a);
      end else begin
         o   = {1'b0, q[8], q[7:0]};
         cnt = cnt - 2 * (q[8] ? 0 : 1) + (a - z);
      end
      return o;
   endfunction

   // one cycle of the driver: sets inputs, checks ready, pushes the expected output
   task automatic step(input bit v, input bit de, input logic [1:0] s, input logic [7:0] d,
                       input string tag, output bit acc);
      bit         exp_rdy;
      string      rtag;
      logic [9:0] s0;
      logic [9:0] s1;
      in_valid = v;
      in_de    = de;
      in_sync  = s;
      in_data  = d;
      #1;
      exp_rdy = !b_busy && (!de || !b_odd);
      rtag = b_busy ? "R5" : ((de && b_odd) ? "R7" : "R2");
      chk(in_ready === exp_rdy, rtag, "in_ready", in_ready, exp_rdy);
      acc = v && exp_rdy;
      if (b_busy) begin
         q_sym.push_back(b_hold); q_de.push_back(1'b1); q_tag.push_back(tag);
         b_busy    = 1'b0;
         b_prev_de = 1'b1;
      end else if (acc && de) begin
         if (!b_prev_de) b_cnt = 0;
         s0 = b_enc({d[7:1], 1'b0}, b_cnt);
         s1 = b_enc({d[7:1], 1'b1}, b_cnt);
         chk(b_cnt == 0, "R3", "disparity after pair", b_cnt, 0);
         q_sym.push_back(s0); q_de.push_back(1'b1); q_tag.push_back(tag);
         b_hold    = s1;
         b_busy    = 1'b1;
         b_prev_de = 1'b1;
      end else begin
         if (acc) b_last = s;
         q_sym.push_back(b_ctrl(b_last)); q_de.push_back(1'b0); q_tag.push_back(tag);
         b_prev_de = 1'b0;
      end
      b_odd = !b_odd;
      @(negedge clk);
   endtask

   task automatic send(input bit de, input logic [1:0] s, input logic [7:0] d, input string tag);
      bit acc;
      acc = 1'b0;
      for (int t = 0; (t < 4) && !acc; t++) step(1'b1, de, s, d, tag, acc);
      chk(acc, tag, "sample taken", acc, 1);
   endtask

   task automatic idle(input int n, input string tag);
      bit acc;
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, 2'b00, 8'h00, tag, acc);
   endtask

   // monitor: pops one expectation per clock edge after reset
   initial begin
      logic [9:0] es;
      bit         ed;
      string      et;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && (q_sym.size() > 0)) begin
            es = q_sym.pop_front();
            ed = q_de.pop_front();
            et = q_tag.pop_front();
            chk(sym_o === es, et, "sym_o", sym_o, es);
            chk(de_o === ed, "R8", "de_o", de_o, ed);
         end
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [9:0] f0;
      logic [9:0] f1;
      int         fc;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(sym_o === 10'b1101010100, "R1", "sym_o after reset", sym_o, 10'b1101010100);
      chk(de_o === 1'b0, "R1", "de_o after reset", de_o, 0);
      chk(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);

      idle(3, "R6");
      // R2: each sync code in blanking
      for (int c = 0; c < 4; c++) send(1'b0, c[1:0], 8'h00, "R2");
      send(1'b0, 2'b10, 8'h00, "R2");
      idle(2, "R6");

      // R3: assorted active values back to back
      send(1'b1, 2'b00, 8'h00, "R3");
      send(1'b1, 2'b00, 8'hFF, "R3");
      send(1'b1, 2'b00, 8'h55, "R3");
      send(1'b1, 2'b00, 8'hAA, "R3");
      send(1'b1, 2'b00, 8'h80, "R3");
      idle(1, "R6");

      // R7: active sample offered on an odd grid cycle waits one cycle
      if (!b_odd) send(1'b0, 2'b01, 8'h00, "R2");
      send(1'b1, 2'b00, 8'h6A, "R7");
      idle(1, "R6");

      // R4: bit 0 of an active sample has no effect
      send(1'b1, 2'b00, 8'h6B, "R4");
      send(1'b1, 2'b00, 8'h6A, "R4");
      send(1'b1, 2'b00, 8'h01, "R4");

      // R3: full sweep of channel values against the reference model
      for (int v = 0; v < 256; v++) send(1'b1, 2'b00, v[7:0], "R3");

      // R6: sync bits of active samples are not remembered
      send(1'b0, 2'b01, 8'h00, "R6");
      if (b_odd) idle(1, "R6");
      send(1'b1, 2'b11, 8'h3C, "R6");
      idle(3, "R6");

      // R5/R8: active samples separated by gaps
      if (b_odd) idle(1, "R8");
      send(1'b1, 2'b00, 8'h12, "R8");
      idle(2, "R8");
      send(1'b1, 2'b00, 8'hE7, "R5");
      idle(2, "R8");
      in_valid = 1'b0;

      // R7: free-running build takes an active sample right after one blanking cycle
      f_valid = 1'b1; f_de = 1'b0; f_sync = 2'b01; f_data = 8'h00;
      @(negedge clk);
      #1;
      chk(f_sym === 10'b0010101011, "R2", "free sym_o blank", f_sym, 10'b0010101011);
      f_de = 1'b1; f_data = 8'h3C;
      #1;
      chk(f_ready === 1'b1, "R7", "free in_ready", f_ready, 1);
      fc = 0;
      f0 = b_enc(8'h3C, fc);
      f1 = b_enc(8'h3D, fc);
      @(negedge clk);
      #1;
      chk(f_sym === f0, "R7", "free first symbol", f_sym, f0);
      chk(f_deo === 1'b1, "R8", "free de_o first", f_deo, 1);
      chk(f_ready === 1'b0, "R5", "free in_ready second", f_ready, 0);
      f_valid = 1'b0;
      @(negedge clk);
      #1;
      chk(f_sym === f1, "R3", "free second symbol", f_sym, f1);
      @(negedge clk);
      #1;
      chk(f_sym === 10'b0010101011, "R6", "free idle sym_o", f_sym, 10'b0010101011);
      chk(f_deo === 1'b0, "R8", "free de_o idle", f_deo, 0);
      chk(q_sym.size() == 0, "R3", "scoreboard drained", q_sym.size(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule